// File: doc/BRIEF.md
# Network Control Register with Pause Frame Requests

This block holds the 32-bit network control word of an Ethernet MAC, together with the 16-bit transmit pause quantum that the control word refers to. Both sit behind a simple register bus. A write is a single-cycle strobe with an address and a data word. Reads are combinational on the address. The block drives level controls for back pressure, statistics write access and the PHY management port. It also drives one-cycle strobes that increment or clear the statistics counters.

Two write-only command bits ask the transmitter for a pause frame. One asks for a zero quantum and the other for the programmed quantum. A request stays pending until the transmitter reports idle. The block then raises a one-cycle start pulse and presents the quantum, which it latched at that moment. When both requests are pending, the zero-quantum request is served first.

The management enable bit gates the management clock and the data-pin output enable that come from an external shift engine. Frame generation and that shift engine are outside this block.

Top module: `mac_net_ctrl`

## Requirements
- R1: At control offset 0x00, the reserved bits 31:13, 10:9 and 3:0 read as 0, and writing 1 to them changes no readable bit and no output.
- R2: The command bits 12, 11, 6 and 5 read back as 0 at all times.
- R3: Bit 8 is read/write and resets to 0. Its value drives `back_pressure_o` from the cycle after the write.
- R4: Bit 7 is read/write and resets to 0. Its value drives `stat_wr_en_o` from the cycle after the write.
- R5: Writing 1 to bit 6 raises `stat_inc_o`, and writing 1 to bit 5 raises `stat_clr_o`. Each is high for exactly the one cycle after the write edge.
- R6: The pause quantum sits at offset 0xBC in bits 15:0 and resets to 0. Bits 31:16 at that offset read as 0 and ignore writes. Any other offset reads as 0.
- R7: Writing 1 to bit 12 makes a zero-quantum pause request pending. Writing 1 to bit 11 makes a programmed-quantum request pending. While `tx_idle_i` is low, no start pulse is issued.
- R8: At a clock edge where a request is pending, `tx_idle_i` is high and `pause_start_o` is low, `pause_start_o` goes high for exactly one cycle and the served request is cleared. As a result, two start pulses are always at least one idle cycle apart.
- R9: When both requests are pending, the zero-quantum request is served first with `pause_quantum_o` = 0. The programmed request follows with the quantum register value.
- R10: `pause_quantum_o` is captured at the issuing edge and holds until the next start pulse, even if the quantum register is rewritten.
- R11: Bit 4 is read/write and resets to 0, and drives `mgmt_en_o`. While it is 0, `mdc_o` and `mdio_oe_o` are 0. While it is 1, they follow `mdc_req_i` and `mdio_oe_req_i`.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| tx_idle_i | input | 1 | Transmitter is idle and may take a pause frame |
| pause_start_o | output | 1 | One-cycle start of a pause frame |
| pause_quantum_o | output | 16 | Quantum for the frame, latched at the start pulse |
| back_pressure_o | output | 1 | Force collisions in half duplex |
| stat_wr_en_o | output | 1 | Statistics counters writable |
| stat_inc_o | output | 1 | One-cycle increment of all counters |
| stat_clr_o | output | 1 | One-cycle clear of all counters |
| mgmt_en_o | output | 1 | Management port enabled |
| mdc_req_i | input | 1 | Management clock from the shift engine |
| mdio_oe_req_i | input | 1 | Management data output enable from the shift engine |
| mdc_o | output | 1 | Gated management clock |
| mdio_oe_o | output | 1 | Gated data output enable, 0 means high impedance |

## Verification
Read data is combinational and is sampled 1 ns after the address changes on a falling edge. Level controls and statistics strobes come from one register stage. They are sampled on the falling edge that follows the write edge, and the strobes are sampled again one cycle later to confirm they fell.

The pause start has one register stage behind the pending flag, which is itself set by the write edge. A start is therefore checked no earlier than the second falling edge after the write. When idle is held, the next pulse is checked two cycles after the previous one, because of the mandatory gap. The management gates are combinational and are checked 1 ns after their inputs change.

// File: rtl/mac_net_ctrl_pkg.sv
package mac_net_ctrl_pkg;
  localparam int unsigned DATA_W = 32;

  localparam int unsigned BIT_ZQ_PAUSE = 12;
  localparam int unsigned BIT_PQ_PAUSE = 11;
  localparam int unsigned BIT_BACK_PR  = 8;
  localparam int unsigned BIT_STAT_WE  = 7;
  localparam int unsigned BIT_STAT_INC = 6;
  localparam int unsigned BIT_STAT_CLR = 5;
  localparam int unsigned BIT_MGMT_EN  = 4;

  // request slots, lower index wins
  localparam int unsigned REQ_ZERO = 0;
  localparam int unsigned REQ_PROG = 1;
  localparam int unsigned N_REQ    = 2;

  typedef struct packed {
    logic back_pr;
    logic stat_we;
    logic mgmt_en;
  } ctrl_lvl_t;
endpackage

// File: rtl/mac_ctrl_regfile.sv
module mac_ctrl_regfile
  import mac_net_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned QUANT_W   = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFF  = 8'h00,
  parameter logic [ADDR_W-1:0] QUANT_OFF = 8'hBC,
  parameter logic [QUANT_W-1:0] QUANT_RST = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output ctrl_lvl_t          lvl_o,
  output logic               inc_o,
  output logic               clr_o,
  output logic [N_REQ-1:0]   req_set_o,
  output logic [QUANT_W-1:0] quant_o
);
  logic ctrl_sel, quant_sel, ctrl_wr, quant_wr;
  ctrl_lvl_t lvl_q;
  logic inc_q, clr_q;
  logic [QUANT_W-1:0] quant_q;
  logic unused_wdata;

  assign ctrl_sel  = (addr_i == CTRL_OFF);
  assign quant_sel = (addr_i == QUANT_OFF);
  assign ctrl_wr   = we_i && ctrl_sel;
  assign quant_wr  = we_i && quant_sel;

  assign unused_wdata = ^{wdata_i[DATA_W-1:BIT_ZQ_PAUSE+1], wdata_i[10:9], wdata_i[3:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      inc_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      inc_q <= ctrl_wr && wdata_i[BIT_STAT_INC];
      clr_q <= ctrl_wr && wdata_i[BIT_STAT_CLR];
      if (ctrl_wr) begin
        lvl_q.back_pr <= wdata_i[BIT_BACK_PR];
        lvl_q.stat_we <= wdata_i[BIT_STAT_WE];
        lvl_q.mgmt_en <= wdata_i[BIT_MGMT_EN];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       quant_q <= QUANT_RST;
    else if (quant_wr) quant_q <= wdata_i[QUANT_W-1:0];
  end

  always_comb begin
    req_set_o = '0;
    req_set_o[REQ_ZERO] = ctrl_wr && wdata_i[BIT_ZQ_PAUSE];
    req_set_o[REQ_PROG] = ctrl_wr && wdata_i[BIT_PQ_PAUSE];
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_sel) begin
      rdata_o[BIT_BACK_PR] = lvl_q.back_pr;
      rdata_o[BIT_STAT_WE] = lvl_q.stat_we;
      rdata_o[BIT_MGMT_EN] = lvl_q.mgmt_en;
    end else if (quant_sel) begin
      rdata_o[QUANT_W-1:0] = quant_q;
    end
  end

  assign lvl_o   = lvl_q;
  assign inc_o   = inc_q;
  assign clr_o   = clr_q;
  assign quant_o = quant_q;

  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_sel |-> (rdata_o[DATA_W-1:13] == '0 && rdata_o[10:9] == 2'b00 && rdata_o[3:0] == 4'h0));
  assert_cmd_read_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_sel |-> (rdata_o[12:11] == 2'b00 && rdata_o[6:5] == 2'b00));
  assert_inc_from_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_q |-> $past(ctrl_wr && wdata_i[BIT_STAT_INC]));
  assert_clr_from_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> $past(ctrl_wr && wdata_i[BIT_STAT_CLR]));
  assert_quant_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(quant_wr) |-> $stable(quant_q));
endmodule

// File: rtl/mac_pause_arb.sv
module mac_pause_arb #(
  parameter int unsigned N_REQ   = 2,
  parameter int unsigned QUANT_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_REQ-1:0]         req_set_i,
  input  logic [N_REQ*QUANT_W-1:0] quant_tab_i,
  input  logic                     tx_idle_i,
  output logic                     start_o,
  output logic [QUANT_W-1:0]       quant_o
);
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [N_REQ-1:0]   pend_q, grant;
  logic               fire;
  logic [IDX_W-1:0]   sel_idx;
  logic               start_q;
  logic [QUANT_W-1:0] quant_q;

  always_comb begin
    grant   = '0;
    sel_idx = '0;
    for (int i = N_REQ-1; i >= 0; i--) begin
      if (pend_q[i]) begin
        grant   = '0;
        grant[i] = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign fire = tx_idle_i && !start_q && (|pend_q);

  for (genvar g = 0; g < N_REQ; g++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= (pend_q[g] && !(fire && grant[g])) || req_set_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      quant_q <= '0;
    end else begin
      start_q <= fire;
      if (fire) quant_q <= quant_tab_i[sel_idx*QUANT_W +: QUANT_W];
    end
  end

  assign start_o = start_q;
  assign quant_o = quant_q;

  assert_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  assert_needs_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> $past(tx_idle_i));
  assert_needs_pend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> $past(|pend_q));
  assert_low_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && $past(pend_q[0])) |-> (quant_q == $past(quant_tab_i[QUANT_W-1:0])));
  assert_quant_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_q |-> $stable(quant_q));
endmodule

// File: rtl/mac_mgmt_gate.sv
module mac_mgmt_gate #(
  parameter int unsigned N_SIG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [N_SIG-1:0] req_i,
  output logic [N_SIG-1:0] out_o
);
  for (genvar g = 0; g < N_SIG; g++) begin : g_gate
    assign out_o[g] = en_i & req_i[g];
  end

  assert_gate_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (out_o == '0));
  assert_gate_on_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (out_o == req_i));
endmodule

// File: rtl/mac_net_ctrl.sv
module mac_net_ctrl
  import mac_net_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned QUANT_W = 16,
  parameter logic [ADDR_W-1:0]  CTRL_OFF  = 8'h00,
  parameter logic [ADDR_W-1:0]  QUANT_OFF = 8'hBC,
  parameter logic [QUANT_W-1:0] QUANT_RST = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               tx_idle_i,
  output logic               pause_start_o,
  output logic [QUANT_W-1:0] pause_quantum_o,
  output logic               back_pressure_o,
  output logic               stat_wr_en_o,
  output logic               stat_inc_o,
  output logic               stat_clr_o,
  output logic               mgmt_en_o,
  input  logic               mdc_req_i,
  input  logic               mdio_oe_req_i,
  output logic               mdc_o,
  output logic               mdio_oe_o
);
  localparam int unsigned N_GATE = 2;

  ctrl_lvl_t                lvl;
  logic [N_REQ-1:0]         req_set;
  logic [QUANT_W-1:0]       quant_reg;
  logic [N_REQ*QUANT_W-1:0] quant_tab;
  logic [N_GATE-1:0]        gate_in, gate_out;

  mac_ctrl_regfile #(
    .ADDR_W(ADDR_W), .QUANT_W(QUANT_W),
    .CTRL_OFF(CTRL_OFF), .QUANT_OFF(QUANT_OFF), .QUANT_RST(QUANT_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .lvl_o(lvl),
    .inc_o(stat_inc_o), .clr_o(stat_clr_o),
    .req_set_o(req_set), .quant_o(quant_reg)
  );

  always_comb begin
    quant_tab = '0;
    quant_tab[REQ_PROG*QUANT_W +: QUANT_W] = quant_reg;
  end

  mac_pause_arb #(.N_REQ(N_REQ), .QUANT_W(QUANT_W)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_set_i(req_set), .quant_tab_i(quant_tab), .tx_idle_i(tx_idle_i),
    .start_o(pause_start_o), .quant_o(pause_quantum_o)
  );

  assign gate_in = {mdio_oe_req_i, mdc_req_i};

  mac_mgmt_gate #(.N_SIG(N_GATE)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(lvl.mgmt_en), .req_i(gate_in), .out_o(gate_out)
  );

  assign mdc_o           = gate_out[0];
  assign mdio_oe_o       = gate_out[1];
  assign back_pressure_o = lvl.back_pr;
  assign stat_wr_en_o    = lvl.stat_we;
  assign mgmt_en_o       = lvl.mgmt_en;

  assert_bp_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_we_i && bus_addr_i == CTRL_OFF) |-> (back_pressure_o == $past(bus_wdata_i[BIT_BACK_PR])));
  assert_swe_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_we_i && bus_addr_i == CTRL_OFF) |-> (stat_wr_en_o == $past(bus_wdata_i[BIT_STAT_WE])));
endmodule

// File: tb/mac_net_ctrl_test.sv
`timescale 1ns/1ps
module mac_net_ctrl_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] RW_MASK = 32'h0000_0190;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_idle = 1'b0;
  logic        pstart;
  logic [15:0] pquant;
  logic        bp, swe, sinc, sclr, men, mdc_req = 1'b0, oe_req = 1'b0, mdc, oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_net_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tx_idle_i(tx_idle), .pause_start_o(pstart), .pause_quantum_o(pquant),
    .back_pressure_o(bp), .stat_wr_en_o(swe), .stat_inc_o(sinc), .stat_clr_o(sclr),
    .mgmt_en_o(men), .mdc_req_i(mdc_req), .mdio_oe_req_i(oe_req),
    .mdc_o(mdc), .mdio_oe_o(oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // returns on the falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 outputs", {25'b0, pstart, bp, swe, sinc, sclr, men, mdc | oe}, '0);
    chk("R12 quantum", {16'b0, pquant}, '0);
    rst_n = 1'b1;
    rd(8'hBC, r); chk("R6 quant reset", r, '0);
    rd(8'h00, r); chk("R12 ctrl reset", r, '0);

    // single-bit sweep over the control word: R1 R2 R3 R4 R5 R11
    tx_idle = 1'b1;
    for (int b = 0; b < 32; b++) begin
      logic [31:0] w;
      w = 32'h1 << b;
      wr(8'h00, w);
      chk("R5 inc pulse", {31'b0, sinc}, {31'b0, (b == 6)});
      chk("R5 clr pulse", {31'b0, sclr}, {31'b0, (b == 5)});
      chk("R3 back pressure", {31'b0, bp}, {31'b0, (b == 8)});
      chk("R4 stat write enable", {31'b0, swe}, {31'b0, (b == 7)});
      chk("R11 mgmt enable", {31'b0, men}, {31'b0, (b == 4)});
      rd(8'h00, r);
      chk((b > 12 || b == 9 || b == 10 || b < 4) ? "R1 reserved" : "R2 readback", r, w & RW_MASK);
      chk("R5 pulse falls", {30'b0, sinc, sclr}, '0);
    end
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, r); chk("R1 all ones", r, RW_MASK);
    wr(8'h00, 32'h0);
    rd(8'h40, r); chk("R6 other offset", r, '0);
    repeat (4) @(negedge clk);
    chk("R8 drained", {31'b0, pstart}, '0);

    // quantum register sweep: R6
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h1111) ^ 16'(i << 3);
      wr(8'hBC, 32'hABCD_0000 | {16'b0, v});
      rd(8'hBC, r); chk("R6 quant rw", r, {16'b0, v});
    end

    // R7 hold while busy, R9 priority, R8 gap
    tx_idle = 1'b0;
    wr(8'hBC, 32'h0000_1234);
    wr(8'h00, 32'h0000_1800);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R7 wait idle", {31'b0, pstart}, '0);
    end
    tx_idle = 1'b1;
    @(negedge clk); chk("R9 zero first start", {31'b0, pstart}, 32'h1);
    chk("R9 zero quantum", {16'b0, pquant}, '0);
    @(negedge clk); chk("R8 gap", {31'b0, pstart}, '0);
    @(negedge clk); chk("R9 prog start", {31'b0, pstart}, 32'h1);
    chk("R9 prog quantum", {16'b0, pquant}, 32'h1234);
    @(negedge clk); chk("R8 one cycle", {31'b0, pstart}, '0);
    tx_idle = 1'b0;
    repeat (3) begin
      @(negedge clk); chk("R8 cleared", {31'b0, pstart}, '0);
    end

    // R10 quantum holds after register rewrite
    wr(8'hBC, 32'h0000_5555);
    @(negedge clk); chk("R10 held quantum", {16'b0, pquant}, 32'h1234);

    // single programmed request with idle already high
    tx_idle = 1'b1;
    wr(8'h00, 32'h0000_0800);
    chk("R8 not yet", {31'b0, pstart}, '0);
    @(negedge clk); chk("R8 start", {31'b0, pstart}, 32'h1);
    chk("R10 new quantum", {16'b0, pquant}, 32'h5555);
    tx_idle = 1'b0;

    // R11 gating sweep
    for (int e = 0; e < 2; e++) begin
      wr(8'h00, e ? 32'h10 : 32'h0);
      for (int m = 0; m < 4; m++) begin
        @(negedge clk);
        mdc_req = m[0]; oe_req = m[1];
        #1;
        chk("R11 mdc", {31'b0, mdc}, {31'b0, (e == 1) && m[0]});
        chk("R11 mdio oe", {31'b0, oe}, {31'b0, (e == 1) && m[1]});
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule